// File: doc/BRIEF.md
# SPI Status, Frame Counter and Request Unit

This unit sits beside the shift engine of an SPI master. It counts the frames that the engine finishes and keeps the completion flags. It also turns the FIFO fill levels into fill and drain requests. Each flag is qualified by its own enable. A qualified fill or drain request goes either to the shared interrupt line or to a DMA request line, as a steering bit selects. Completion flags are cleared by software with write-one-to-clear. Reading the status word and writing the same value back therefore acknowledges exactly what was seen.

The shift engine reports each finished frame with a one-cycle `frame_done` pulse. The pulse carries two bits from that frame's command word: an end-of-queue mark and a counter-clear request. A simple write port addresses three registers, selected by `reg_addr`: 0 is status, 1 is enable and 2 is counter. Writes to code 3 are ignored. All three registers are always visible on output ports.

Register bits used: status bit 31 is transfer complete, bit 28 is end of queue, bit 25 is TX fill request and bit 17 is RX drain request. Enable bits 31, 28, 25 and 17 enable those flags. Enable bit 24 steers the TX fill flag to DMA, and bit 16 steers the RX drain flag to DMA. The counter sits in bits 31:16 of the counter register.

Top module: `spi_stat_unit`

## Requirements
- R1: While `rst_n` is low, the status, enable and counter registers read 0, and `irq`, `tx_dma_req` and `rx_dma_req` are 0.
- R2: Each `frame_done` pulse without counter-clear adds one to the frame counter in counter-register bits 31:16. Bits 15:0 read 0.
- R3: The frame counter wraps from 65535 to 0 on the next counted frame.
- R4: A `frame_done` pulse with `frame_clr_cnt` high restarts the count, so the counter reads 1 after that frame.
- R5: A write to code 2 loads `reg_wdata[31:16]` into the counter on the next clock edge. The write wins over a frame finishing in the same cycle.
- R6: Status bit 31 sets one cycle after every `frame_done` pulse. Status bit 28 sets only when the pulse carries `frame_eoq`.
- R7: A write to code 0 clears each of bits 31 and 28 whose `reg_wdata` bit is 1 and leaves the others alone. A set in the same cycle wins over the clear.
- R8: Status bit 25 shows `tx_level` below the FIFO depth, and status bit 17 shows `rx_level` non-zero, one clock after the level. Writes do not clear them.
- R9: The enable register keeps only bits 31, 28, 25, 24, 17 and 16 of a write to code 1. Every other bit reads 0. A write to code 3 changes no register.
- R10: `irq` is high when any of these holds: bit 31 set and enabled; bit 28 set and enabled; bit 25 set, enabled and not steered; bit 17 set, enabled and not steered.
- R11: `tx_dma_req` is high while status bit 25 and enable bits 25 and 24 are all set. `rx_dma_req` is high while status bit 17 and enable bits 17 and 16 are all set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | 1 | One-cycle pulse when a frame finishes |
| frame_eoq | input | 1 | End-of-queue mark of the finishing frame |
| frame_clr_cnt | input | 1 | Counter-clear request of the finishing frame |
| tx_level | input | LVL_W | TX FIFO fill level |
| rx_level | input | LVL_W | RX FIFO fill level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 counter |
| reg_wdata | input | 32 | Write data |
| status_reg | output | 32 | Status flags |
| count_reg | output | 32 | Frame counter in bits 31:16 |
| enable_reg | output | 32 | Enable and steering bits |
| irq | output | 1 | Interrupt request |
| tx_dma_req | output | 1 | TX fill DMA request |
| rx_dma_req | output | 1 | RX drain DMA request |

## Verification
The bench builds the unit with its default parameters: a 16-bit counter and a FIFO depth of 4, so the levels are 3 bits wide. With that depth, a full TX FIFO and an empty RX FIFO are both easy to drive, so every combination of the fill and drain flags can be set. The counter wrap is reached by loading 65535 through the counter register rather than by counting 65536 frames. The steering table covers each flag routed to the interrupt line, to DMA and to neither.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam int BIT_TC  = 31;
    localparam int BIT_EOQ = 28;
    localparam int BIT_TXF = 25;
    localparam int BIT_TXD = 24;
    localparam int BIT_RXF = 17;
    localparam int BIT_RXD = 16;

    localparam logic [31:0] EN_MASK = (32'd1 << BIT_TC) | (32'd1 << BIT_EOQ)
                                    | (32'd1 << BIT_TXF) | (32'd1 << BIT_TXD)
                                    | (32'd1 << BIT_RXF) | (32'd1 << BIT_RXD);

endpackage

// File: rtl/spi_frame_counter.sv
module spi_frame_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    input  logic             frame_clr_cnt,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (frame_done) begin
            // A clearing frame restarts the count and is itself counted
            count_q <= frame_clr_cnt ? CNT_W'(1) : count_q + CNT_W'(1);
        end
    end

    assign count = count_q;

endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit #(
    parameter int DEPTH = 4,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    input  logic             frame_eoq,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             clr_tc,
    input  logic             clr_eoq,
    output logic             tc_flag,
    output logic             eoq_flag,
    output logic             txf_flag,
    output logic             rxf_flag
);

    logic tc_q, eoq_q, txf_q, rxf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q  <= 1'b0;
            eoq_q <= 1'b0;
            txf_q <= 1'b0;
            rxf_q <= 1'b0;
        end else begin
            // Set has priority over a write-one clear in the same cycle
            tc_q  <= frame_done | (tc_q & ~clr_tc);
            eoq_q <= (frame_done & frame_eoq) | (eoq_q & ~clr_eoq);
            txf_q <= (tx_level < LVL_W'(DEPTH));
            rxf_q <= (rx_level != '0);
        end
    end

    assign tc_flag  = tc_q;
    assign eoq_flag = eoq_q;
    assign txf_flag = txf_q;
    assign rxf_flag = rxf_q;

endmodule

// File: rtl/spi_req_router.sv
module spi_req_router
    import spi_stat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_wr,
    input  logic [31:0] en_wdata,
    input  logic        tc_flag,
    input  logic        eoq_flag,
    input  logic        txf_flag,
    input  logic        rxf_flag,
    output logic [31:0] enable,
    output logic        irq,
    output logic        tx_dma_req,
    output logic        rx_dma_req
);

    logic [31:0] en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= en_wdata & EN_MASK;
        end
    end

    always_comb begin
        irq = (tc_flag  & en_q[BIT_TC])
            | (eoq_flag & en_q[BIT_EOQ])
            | (txf_flag & en_q[BIT_TXF] & ~en_q[BIT_TXD])
            | (rxf_flag & en_q[BIT_RXF] & ~en_q[BIT_RXD]);
        tx_dma_req = txf_flag & en_q[BIT_TXF] & en_q[BIT_TXD];
        rx_dma_req = rxf_flag & en_q[BIT_RXF] & en_q[BIT_RXD];
    end

    assign enable = en_q;

endmodule

// File: rtl/spi_stat_unit.sv
module spi_stat_unit
    import spi_stat_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DEPTH = 4,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    input  logic             frame_eoq,
    input  logic             frame_clr_cnt,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      status_reg,
    output logic [31:0]      count_reg,
    output logic [31:0]      enable_reg,
    output logic             irq,
    output logic             tx_dma_req,
    output logic             rx_dma_req
);

    localparam int PAD_W = 32 - CNT_W;

    reg_sel_e         sel;
    logic             wr_status, wr_enable, wr_count;
    logic             tc_flag, eoq_flag, txf_flag, rxf_flag;
    logic [CNT_W-1:0] count;

    always_comb begin
        sel       = reg_sel_e'(reg_addr);
        wr_status = 1'b0;
        wr_enable = 1'b0;
        wr_count  = 1'b0;
        unique case (sel)
            SEL_STATUS: wr_status = reg_wr;
            SEL_ENABLE: wr_enable = reg_wr;
            SEL_COUNT:  wr_count  = reg_wr;
            SEL_NONE:   ;
        endcase
    end

    spi_frame_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_done    (frame_done),
        .frame_clr_cnt (frame_clr_cnt),
        .load          (wr_count),
        .load_val      (reg_wdata[31 -: CNT_W]),
        .count         (count)
    );

    spi_flag_unit #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_eoq  (frame_eoq),
        .tx_level   (tx_level),
        .rx_level   (rx_level),
        .clr_tc     (wr_status & reg_wdata[BIT_TC]),
        .clr_eoq    (wr_status & reg_wdata[BIT_EOQ]),
        .tc_flag    (tc_flag),
        .eoq_flag   (eoq_flag),
        .txf_flag   (txf_flag),
        .rxf_flag   (rxf_flag)
    );

    spi_req_router u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_wr      (wr_enable),
        .en_wdata   (reg_wdata),
        .tc_flag    (tc_flag),
        .eoq_flag   (eoq_flag),
        .txf_flag   (txf_flag),
        .rxf_flag   (rxf_flag),
        .enable     (enable_reg),
        .irq        (irq),
        .tx_dma_req (tx_dma_req),
        .rx_dma_req (rx_dma_req)
    );

    always_comb begin
        status_reg          = '0;
        status_reg[BIT_TC]  = tc_flag;
        status_reg[BIT_EOQ] = eoq_flag;
        status_reg[BIT_TXF] = txf_flag;
        status_reg[BIT_RXF] = rxf_flag;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign count_reg = {count, {PAD_W{1'b0}}};
        end else begin : g_full
            assign count_reg = count;
        end
    endgenerate

endmodule

// File: rtl/spi_stat_chk.sv
module spi_stat_chk #(
    parameter int CNT_W = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_done,
    input logic        frame_eoq,
    input logic        frame_clr_cnt,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] status_reg,
    input logic [31:0] count_reg,
    input logic [31:0] enable_reg,
    input logic        irq,
    input logic        tx_dma_req,
    input logic        rx_dma_req
);

    logic cnt_wr;
    assign cnt_wr = reg_wr && (reg_addr == 2'd2);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_clr_cnt && !cnt_wr)
        |=> (count_reg[31 -: CNT_W] == $past(count_reg[31 -: CNT_W]) + CNT_W'(1)));

    // R3
    count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_clr_cnt && !cnt_wr && (&count_reg[31 -: CNT_W]))
        |=> (count_reg[31 -: CNT_W] == '0));

    // R4
    count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_clr_cnt && !cnt_wr)
        |=> (count_reg[31 -: CNT_W] == CNT_W'(1)));

    // R6
    eoq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_reg[28]) |-> $past(frame_done && frame_eoq));

    // R7
    eoq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[28] && !(frame_done && frame_eoq))
        |=> !status_reg[28]);

    // R11
    dma_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_dma_req || rx_dma_req) |-> (enable_reg[24] || enable_reg[16]));

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((status_reg & enable_reg) != '0));

endmodule

bind spi_stat_unit spi_stat_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_spi_stat_unit.sv
module sim_spi_stat_unit;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int LVL_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_done = 1'b0, frame_eoq = 1'b0, frame_clr_cnt = 1'b0;
    logic [LVL_W-1:0] tx_level = 3'd4, rx_level = 3'd0;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      status_reg, count_reg, enable_reg;
    logic             irq, tx_dma_req, rx_dma_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_stat_unit u0 (.*);

    // {en31,en28,en25,en24,en17,en16}, tx_level, rx_level, {irq,txdma,rxdma}
    localparam int NV = 8;
    localparam logic [14:0] VEC [NV] = '{
        {6'b000000, 3'd0, 3'd1, 3'b000},
        {6'b001000, 3'd0, 3'd0, 3'b100},
        {6'b001100, 3'd0, 3'd0, 3'b010},
        {6'b000010, 3'd4, 3'd2, 3'b100},
        {6'b000011, 3'd4, 3'd2, 3'b001},
        {6'b001111, 3'd4, 3'd0, 3'b000},
        {6'b001111, 3'd3, 3'd4, 3'b011},
        {6'b111111, 3'd4, 3'd0, 3'b000}
    };

    function automatic logic [31:0] en_word(input logic [5:0] e);
        en_word = '0;
        en_word[31] = e[5]; en_word[28] = e[4]; en_word[25] = e[3];
        en_word[24] = e[2]; en_word[17] = e[1]; en_word[16] = e[0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic frame(input logic eoq, input logic clr);
        @(negedge clk);
        frame_done = 1'b1; frame_eoq = eoq; frame_clr_cnt = clr;
        @(negedge clk);
        frame_done = 1'b0; frame_eoq = 1'b0; frame_clr_cnt = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 status", status_reg, 32'h0);
        check("R1 count", count_reg, 32'h0);
        check("R1 enable", enable_reg, 32'h0);
        check("R1 outputs", {29'd0, irq, tx_dma_req, rx_dma_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R6: plain frames
        repeat (3) frame(1'b0, 1'b0);
        check("R2 count three", count_reg, 32'h0003_0000);
        check("R6 tc set eoq clear", status_reg, 32'h8000_0000);
        frame(1'b1, 1'b0);
        check("R6 eoq set", status_reg, 32'h9000_0000);
        check("R2 count four", count_reg, 32'h0004_0000);

        // R10, R7
        wr(2'd1, 32'h8000_0000);
        check("R10 irq on tc", {31'd0, irq}, 32'd1);
        wr(2'd0, 32'h1000_0000);
        check("R7 clear eoq only", status_reg, 32'h8000_0000);
        check("R10 irq stays", {31'd0, irq}, 32'd1);
        wr(2'd0, 32'h8000_0000);
        check("R7 clear tc", status_reg, 32'h0);
        check("R10 irq drops", {31'd0, irq}, 32'd0);

        // R7 set wins over clear
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h9000_0000;
        frame_done = 1'b1; frame_eoq = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; frame_done = 1'b0; frame_eoq = 1'b0;
        check("R7 set wins", status_reg, 32'h9000_0000);

        // R5 load, R3 wrap, R4 clear
        wr(2'd2, 32'hFFFF_1234);
        check("R5 load", count_reg, 32'hFFFF_0000);
        frame(1'b0, 1'b0);
        check("R3 wrap", count_reg, 32'h0);
        frame(1'b0, 1'b0);
        frame(1'b0, 1'b0);
        frame(1'b0, 1'b1);
        check("R4 clear frame", count_reg, 32'h0001_0000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0050_0000;
        frame_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; frame_done = 1'b0;
        check("R5 load beats frame", count_reg, 32'h0050_0000);

        // R9 enable mask, ignored code 3
        wr(2'd1, 32'hFFFF_FFFF);
        check("R9 enable mask", enable_reg, 32'h9303_0000);
        wr(2'd3, 32'h0000_0000);
        check("R9 code3 enable", enable_reg, 32'h9303_0000);
        check("R9 code3 count", count_reg, 32'h0050_0000);
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'h0);

        // R8 live flags not cleared by writes
        tx_level = 3'd0; rx_level = 3'd3;
        @(negedge clk);
        check("R8 live flags", status_reg, 32'h0202_0000);
        wr(2'd0, 32'hFFFF_FFFF);
        check("R8 write no clear", status_reg, 32'h0202_0000);
        tx_level = 3'd4; rx_level = 3'd0;
        @(negedge clk);
        check("R8 flags drop", status_reg, 32'h0);

        // R10, R11 routing table
        for (int i = 0; i < NV; i++) begin
            wr(2'd1, en_word(VEC[i][14:9]));
            tx_level = VEC[i][8:6];
            rx_level = VEC[i][5:3];
            @(negedge clk);
            check("R10 R11 routing", {29'd0, irq, tx_dma_req, rx_dma_req},
                  {29'd0, VEC[i][2:0]});
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule